// File: doc/BRIEF.md
# Five-Pin Bidirectional Port Register Block

This block is a small general-purpose I/O port for a microcontroller. It has five pins and two byte-wide registers on a simple synchronous register bus.

- **Direction register.** Each bit sets whether a pin drives its output. Software can write this register but cannot read it back. Any read of its address returns all ones.
- **Data register.** It holds the output values. A read of it returns the stored bit for pins that are outputs and the synchronized live pin level for pins that are inputs. The three upper bits have no pins. They read as ones and ignore writes.

After reset, the uppermost pin comes up as an output driving low, so it can serve at once as the first chip-select line. The lower pins start as inputs.

There are three kinds of reset or standby:
- A reset or an active hardware-standby level returns both registers to their initial values. Hardware standby wins if both standby inputs are high.
- Software standby freezes both registers and ignores writes, so a pin that is an output keeps driving.

Pin inputs pass through a two-flop synchronizer before any read uses them. Read data is registered and appears the cycle after the read strobe.

Top module: `gpio5_port`

## Requirements
- R1: After reset, `pin_oe` is 5'b10000, `pin_out` is 5'b00000 and `bus_rdata` is 8'hFF. A read of the data register (address 1) with all pins low returns 8'hE0.
- R2: A read of the direction register (address 0) returns 8'hFF whatever was written to it.
- R3: A write to address 0 sets `pin_oe` to the write data's bits 4:0 from the clock edge of the write. Bits 7:5 of that write have no visible effect.
- R4: A write to address 1 sets `pin_out` to the write data's bits 4:0. Bits 7:5 of any data-register read are 1.
- R5: In a data-register read, each bit 4:0 whose direction bit is 1 returns the stored data bit. Each bit whose direction bit is 0 returns the synchronized pin level.
- R6: A pin change made between clock edges is first seen by a read strobe sampled on the third edge after the change. Reads sampled on the first and second edges return the old level.
- R7: `bus_rdata` changes only on the clock edge where `bus_rd` is sampled high, and it holds while `bus_rd` is low.
- R8: A read of any address other than 0 and 1 returns 8'hFF.
- R9: While `hw_stby` is high, both registers are held at their initial values (`pin_oe` 5'b10000, `pin_out` 0) and writes are ignored.
- R10: While `sw_stby` is high and `hw_stby` is low, both registers keep their values, writes are ignored, reads still work, and output pins keep driving.
- R11: When `hw_stby` and `sw_stby` are both high, hardware standby takes effect and the registers return to their initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby level: resets registers |
| sw_stby | input | 1 | Software standby level: freezes registers |
| bus_addr | input | 4 | Register address (0 direction, 1 data) |
| bus_wr | input | 1 | Write strobe, acts on the clock edge |
| bus_rd | input | 1 | Read strobe, data registered on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 5 | Pin levels from the pads |
| pin_out | output | 5 | Output values to the pads |
| pin_oe | output | 5 | Per-pin output enable |

## Verification
Register writes and standby levels show up at `pin_oe` and `pin_out` one edge after they are sampled. Read data appears on `bus_rdata` one edge after the strobe. A pin change takes two synchronizer edges before a read strobe can capture it. The bench drives all inputs on falling edges and checks pin outputs on the next falling edge. A read's expected value goes into a queue when the strobe is driven. The monitor pops it on the falling edge after the capturing edge. The synchronizer test issues three reads back to back, starting on the cycle of the pin change, so the edge where the new level first appears is pinned down exactly.

// File: rtl/gpio5_pkg.sv
package gpio5_pkg;
    localparam int P_PINS   = 5;
    localparam int P_DW     = 8;
    localparam int P_AW     = 4;
    localparam int P_HI     = P_DW - P_PINS;
    localparam logic [P_AW-1:0]   A_DIR  = P_AW'(0);
    localparam logic [P_AW-1:0]   A_DATA = P_AW'(1);
    localparam logic [P_PINS-1:0] DIR_INIT  = P_PINS'(5'b10000);
    localparam logic [P_PINS-1:0] DATA_INIT = '0;

    typedef struct packed {
        logic [P_PINS-1:0] dir;
        logic [P_PINS-1:0] dat;
    } port_regs_t;
endpackage

// File: rtl/gpio5_sync.sv
module gpio5_sync
    import gpio5_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [P_PINS-1:0] pin_raw,
    output logic [P_PINS-1:0] pin_syn
);
    for (genvar g = 0; g < P_PINS; g++) begin : g_bit
        logic [1:0] stg_d, stg_q;
        always_comb stg_d = {stg_q[0], pin_raw[g]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= '0;
            else        stg_q <= stg_d;
        end
        assign pin_syn[g] = stg_q[1];
    end
endmodule

// File: rtl/gpio5_regs.sv
module gpio5_regs
    import gpio5_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              wr,
    input  logic [P_AW-1:0]   addr,
    input  logic [P_PINS-1:0] wdat,
    output port_regs_t        regs
);
    localparam port_regs_t INIT = '{dir: DIR_INIT, dat: DATA_INIT};
    port_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hw_stby) begin
            st_d = INIT;
        end else if (!sw_stby && wr) begin
            if (addr == A_DIR)  st_d.dir = wdat;
            if (addr == A_DATA) st_d.dat = wdat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= INIT;
        else        st_q <= st_d;
    end

    assign regs = st_q;

    assert_hw_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (st_q == INIT));
    assert_both_hw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_stby && sw_stby) |=> (st_q.dir == DIR_INIT));
    assert_sw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> $stable(st_q));
endmodule

// File: rtl/gpio5_rdmux.sv
module gpio5_rdmux
    import gpio5_pkg::*;
(
    input  logic [P_AW-1:0]   addr,
    input  port_regs_t        regs,
    input  logic [P_PINS-1:0] pin_syn,
    output logic [P_DW-1:0]   rdat
);
    logic [P_PINS-1:0] mixed;
    always_comb begin
        mixed = (regs.dir & regs.dat) | (~regs.dir & pin_syn);
        if (addr == A_DATA) rdat = {{P_HI{1'b1}}, mixed};
        else                rdat = '1;
    end
endmodule

// File: rtl/gpio5_port.sv
module gpio5_port
    import gpio5_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [P_AW-1:0]   bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [P_DW-1:0]   bus_wdata,
    output logic [P_DW-1:0]   bus_rdata,
    input  logic [P_PINS-1:0] pin_in,
    output logic [P_PINS-1:0] pin_out,
    output logic [P_PINS-1:0] pin_oe
);
    logic [P_PINS-1:0] pin_syn;
    port_regs_t        regs;
    logic [P_DW-1:0]   rd_mux;
    logic [P_DW-1:0]   rd_d, rd_q;
    logic              wdata_unused_hi;

    assign wdata_unused_hi = ^bus_wdata[P_DW-1:P_PINS];

    gpio5_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_in),
        .pin_syn (pin_syn)
    );

    gpio5_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdat    (bus_wdata[P_PINS-1:0]),
        .regs    (regs)
    );

    gpio5_rdmux u_rdmux (
        .addr    (bus_addr),
        .regs    (regs),
        .pin_syn (pin_syn),
        .rdat    (rd_mux)
    );

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) rd_d = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '1;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q;
    assign pin_out   = regs.dat;
    assign pin_oe    = regs.dir;

    assert_dir_reads_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_DIR) |=> (bus_rdata == '1));
    assert_unmapped_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != A_DIR && bus_addr != A_DATA) |=> (bus_rdata == '1));
    assert_hi_bits_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_DATA) |=> (bus_rdata[P_DW-1:P_PINS] == '1));
    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    assert_out_pins_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_DATA) |=>
            ((bus_rdata[P_PINS-1:0] & pin_oe) == (pin_out & $past(pin_oe))));
endmodule

// File: tb/sim_gpio5_port.sv
module sim_gpio5_port;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       hw_stby = 0, sw_stby = 0;
    logic [3:0] bus_addr = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [4:0] pin_in = 0;
    logic [4:0] pin_out, pin_oe;

    int total = 0, fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       pend = 0;

    always #2.5 clk = ~clk;

    gpio5_port u0 (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_wr = 0; bus_rd = 1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_rd = 0; bus_wr = 0;
        end
    endtask

    always @(posedge clk) pend <= bus_rd;

    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                total++; fails++;
                $display("FAIL R7: unexpected read result %h expected none", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 5);
        total++; fails++;
        $display("FAIL watchdog: run ended at %0t expected earlier finish", $time);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({3'b0, pin_oe}, 8'h10, "R1 oe in reset");
        chk({3'b0, pin_out}, 8'h00, "R1 out in reset");
        chk(bus_rdata, 8'hFF, "R1 rdata in reset");
        rst_n = 1;
        idle(3);
        rd(4'd1, 8'hE0, "R1 data read after reset");
        rd(4'd0, 8'hFF, "R2 dir read after reset");
        idle(1);
        // R3 direction writes
        wr(4'd0, 8'hFF);
        chk({3'b0, pin_oe}, 8'h1F, "R3 oe all");
        wr(4'd0, 8'h0F);
        chk({3'b0, pin_oe}, 8'h0F, "R3 oe upper bits no effect");
        rd(4'd0, 8'hFF, "R2 dir read after write");
        idle(1);
        // R4 data writes
        wr(4'd1, 8'h15);
        chk({3'b0, pin_out}, 8'h15, "R4 out value");
        rd(4'd1, 8'hE5, "R5 mix, pin4 input low");
        idle(1);
        pin_in = 5'b11010;
        idle(3);
        rd(4'd1, 8'hF5, "R5 mix, pin4 input high");
        idle(1);
        // R6 synchronizer latency
        wr(4'd0, 8'h00);
        pin_in = 5'b00000;
        idle(4);
        rd(4'd1, 8'hE0, "R6 first edge old");
        pin_in = 5'b00001;
        rd(4'd1, 8'hE0, "R6 second edge old");
        rd(4'd1, 8'hE1, "R6 third edge new");
        idle(1);
        // R7 hold while idle
        idle(3);
        chk(bus_rdata, 8'hE1, "R7 rdata holds");
        // R8 unmapped
        rd(4'd2, 8'hFF, "R8 unmapped addr 2");
        rd(4'd15, 8'hFF, "R8 unmapped addr 15");
        idle(1);
        // R10 software standby
        wr(4'd0, 8'h1F);
        wr(4'd1, 8'h0A);
        @(negedge clk); sw_stby = 1;
        wr(4'd0, 8'h00);
        wr(4'd1, 8'h15);
        chk({3'b0, pin_oe}, 8'h1F, "R10 oe kept");
        chk({3'b0, pin_out}, 8'h0A, "R10 out kept");
        rd(4'd1, 8'hEA, "R10 read in sw standby");
        idle(1);
        sw_stby = 0;
        // R9 hardware standby
        hw_stby = 1;
        idle(1);
        chk({3'b0, pin_oe}, 8'h10, "R9 oe reset");
        chk({3'b0, pin_out}, 8'h00, "R9 out reset");
        wr(4'd1, 8'h1F);
        chk({3'b0, pin_out}, 8'h00, "R9 write ignored");
        hw_stby = 0;
        // R11 both standbys
        wr(4'd0, 8'h1F);
        wr(4'd1, 8'h1F);
        @(negedge clk); hw_stby = 1; sw_stby = 1;
        idle(1);
        chk({3'b0, pin_oe}, 8'h10, "R11 oe reset");
        chk({3'b0, pin_out}, 8'h00, "R11 out reset");
        hw_stby = 0; sw_stby = 0;
        idle(2);
        if (exp_q.size() != 0) begin
            total++; fails++;
            $display("FAIL R7: %0d reads left unanswered expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule